// File: doc/BRIEF.md
# Four-Channel Clear-On-Read Interrupt Aggregator

This block gathers event pulses from four line channels into one active-low interrupt line. Each channel keeps two 8-bit sticky status registers. Each status register has an 8-bit mask register beside it. A channel summary register holds one bit per channel, and that bit is set while the channel has an unmasked captured bit. A host that sees the interrupt line low reads the summary first to find the requesting channel. It then reads that channel's two status registers. Each status read returns the captured bits and clears them. When nothing unmasked remains, the summary bit drops, and the interrupt line rises once all summary bits are zero.

Access goes through a synchronous register bus with an address, a read strobe, a write strobe, write data and registered read data. Read data is valid in the cycle after the strobe. A small read-tracking state machine has two states. `ST_IDLE` means no access is in flight. `ST_HOLD` is the cycle after a read. It moves along three transitions: `T_START` (`ST_IDLE` to `ST_HOLD` on a read strobe), `T_EXTEND` (`ST_HOLD` stays in `ST_HOLD` on a back-to-back read) and `T_RELEASE` (`ST_HOLD` to `ST_IDLE` with no read, where events held during the read are merged). A mode bit, called visible mode, lets masked events be captured and shown in the status registers for polling. These bits never reach the summary or the interrupt line.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every mask register reads 0xFF, every status register reads 0, the summary reads 0, the mode register reads 0 and `irq_n` is 1.
- R2: With the mode bit at 0, an event on a masked bit is not captured. Its status register reads 0 and `irq_n` stays 1.
- R3: An event on an unmasked bit sets that bit in its status register. It stays set until the register is read. The summary bit of the channel (bit n for channel n) is then set.
- R4: A read of a status register returns its captured bits and clears them. The channel's summary bit clears after the read only if the channel has no other unmasked captured bit.
- R5: `irq_n` is the registered NOR of the summary bits. After an unmasked event pulse in cycle E with the bus idle, `irq_n` is still 1 in cycle E+2 and is 0 in cycle E+3. It returns to 1 once every unmasked captured bit has been read.
- R6: During a read strobe cycle and the cycle after it, the status registers and the summary do not change. An event arriving in either cycle is held and merged afterwards, so a later read returns it.
- R7: With the mode bit (bit 0 at offset 0x04) at 1, events on masked bits are captured and returned by status reads. They do not set summary bits and do not drive `irq_n` low.
- R8: Clearing a mask bit whose status bit is already captured raises the channel's summary bit and drives `irq_n` low without a new event.
- R9: The register map is as follows. The summary is at 0x00 and the mode is at 0x04. For channel n (0..3), the base address is 0x10·(n+1). Status A is at base+0, status B at base+1, mask A at base+2 and mask B at base+3. Mask bit i covers status bit i. Event vector bit n·8+i feeds bit i of channel n. Unmapped addresses read 0.
- R10: Reading the summary does not clear it, and no mask affects the bit of a channel that has an unmasked captured bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the strobe |
| evt_a | input | 32 | Event pulses for the status A registers, 8 bits per channel |
| evt_b | input | 32 | Event pulses for the status B registers, 8 bits per channel |
| irq_n | output | 1 | Interrupt request, active low, level type |

## Verification
A sweep drives a single pulse onto each of the 64 event bits in turn with everything unmasked. It checks that only the matching channel's summary bit and only the matching status bit appear, with exact interrupt timing. This separates address decoding and bit placement errors from wrong clear behaviour. Repeating the sweep fully masked in default mode and then in visible mode separates "not captured" from "captured but not reported". A final group of patterns isolates one behaviour each:
- an event landing in the read cycle and in the following cycle (freeze and merge);
- two status registers pending in one channel (partial release of the summary);
- two channels pending together (the summary acting as a pointer);
- unmasking a bit that was already captured.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } rd_state_t;

    localparam logic [7:0] ADDR_SUMMARY = 8'h00;
    localparam logic [7:0] ADDR_MODE    = 8'h04;
    localparam logic [3:0] OFF_STAT_A   = 4'h0;
    localparam logic [3:0] OFF_STAT_B   = 4'h1;
    localparam logic [3:0] OFF_MASK_A   = 4'h2;
    localparam logic [3:0] OFF_MASK_B   = 4'h3;
endpackage

// File: rtl/irqagg_rd_fsm.sv
module irqagg_rd_fsm
    import irqagg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rd,
    output logic freeze,
    output logic merge
);
    rd_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bus_rd) state_d = ST_HOLD;   // T_START
            ST_HOLD: if (!bus_rd) state_d = ST_IDLE;  // T_RELEASE, else T_EXTEND
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        freeze = 1'b0;
        merge  = 1'b0;
        unique case (state_q)
            ST_IDLE: freeze = bus_rd;
            ST_HOLD: begin
                freeze = 1'b1;
                merge  = !bus_rd;
            end
            default: ;
        endcase
    end

    // R6: the hold state is only ever entered from a read strobe
    p_hold_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> $past(bus_rd));
endmodule

// File: rtl/irqagg_channel.sv
module irqagg_channel #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt0,
    input  logic [W-1:0] evt1,
    input  logic         freeze,
    input  logic         merge,
    input  logic [1:0]   rd_hit,
    input  logic [1:0]   mask_we,
    input  logic [W-1:0] wdata,
    input  logic         vis,
    output logic [W-1:0] view0,
    output logic [W-1:0] view1,
    output logic [W-1:0] mask0,
    output logic [W-1:0] mask1,
    output logic         gis
);
    logic [W-1:0] stat_q [2];
    logic [W-1:0] pend_q [2];
    logic [W-1:0] mask_q [2];
    logic [W-1:0] evt_v  [2];

    assign evt_v[0] = evt0;
    assign evt_v[1] = evt1;

    for (genvar k = 0; k < 2; k++) begin : g_reg
        logic [W-1:0] capt;
        assign capt = evt_v[k] & (~mask_q[k] | {W{vis}});

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat_q[k] <= '0;
                pend_q[k] <= '0;
                mask_q[k] <= '1;
            end else begin
                if (mask_we[k]) mask_q[k] <= wdata;
                if (rd_hit[k]) begin
                    stat_q[k] <= '0;
                    pend_q[k] <= pend_q[k] | capt;
                end else if (merge) begin
                    stat_q[k] <= stat_q[k] | pend_q[k] | capt;
                    pend_q[k] <= '0;
                end else if (freeze) begin
                    pend_q[k] <= pend_q[k] | capt;
                end else begin
                    stat_q[k] <= stat_q[k] | capt;
                end
            end
        end

        // R4: a read leaves the register empty in the next cycle
        p_clear_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
            rd_hit[k] |=> (stat_q[k] == '0));
        // R6: no change while frozen unless merging
        p_frozen_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (freeze && !merge && !rd_hit[k]) |=> $stable(stat_q[k]));
        // R2: default mode never captures masked bits
        p_masked_no_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!vis && !freeze && !mask_we[k]) |=>
                ((stat_q[k] & ~$past(stat_q[k]) & mask_q[k]) == '0));
    end

    assign mask0 = mask_q[0];
    assign mask1 = mask_q[1];
    assign view0 = vis ? stat_q[0] : (stat_q[0] & ~mask_q[0]);
    assign view1 = vis ? stat_q[1] : (stat_q[1] & ~mask_q[1]);
    assign gis   = |(stat_q[0] & ~mask_q[0]) | |(stat_q[1] & ~mask_q[1]);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int W      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [W-1:0]        bus_wdata,
    output logic [W-1:0]        bus_rdata,
    input  logic [NUM_CH*W-1:0] evt_a,
    input  logic [NUM_CH*W-1:0] evt_b,
    output logic                irq_n
);
    localparam int SUMW = NUM_CH;

    logic            freeze, merge;
    logic            vis_q;
    logic [SUMW-1:0] summary_q, gis;
    logic [W-1:0]    view0 [NUM_CH];
    logic [W-1:0]    view1 [NUM_CH];
    logic [W-1:0]    mask0 [NUM_CH];
    logic [W-1:0]    mask1 [NUM_CH];
    logic [W-1:0]    rd_val;
    logic [3:0]      offs;

    assign offs = bus_addr[3:0];

    irqagg_rd_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_rd (bus_rd),
        .freeze (freeze),
        .merge  (merge)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic       hit;
        logic [1:0] rd_hit, mask_we;
        assign hit        = (bus_addr[7:4] == 4'(n + 1));
        assign rd_hit[0]  = bus_rd && hit && (offs == OFF_STAT_A);
        assign rd_hit[1]  = bus_rd && hit && (offs == OFF_STAT_B);
        assign mask_we[0] = bus_wr && !bus_rd && hit && (offs == OFF_MASK_A);
        assign mask_we[1] = bus_wr && !bus_rd && hit && (offs == OFF_MASK_B);

        irqagg_channel #(.W(W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt0    (evt_a[n*W +: W]),
            .evt1    (evt_b[n*W +: W]),
            .freeze  (freeze),
            .merge   (merge),
            .rd_hit  (rd_hit),
            .mask_we (mask_we),
            .wdata   (bus_wdata),
            .vis     (vis_q),
            .view0   (view0[n]),
            .view1   (view1[n]),
            .mask0   (mask0[n]),
            .mask1   (mask1[n]),
            .gis     (gis[n])
        );
    end

    always_comb begin
        rd_val = '0;
        if (bus_addr == ADDR_SUMMARY) rd_val = W'(summary_q);
        else if (bus_addr == ADDR_MODE) rd_val = W'(vis_q);
        for (int n = 0; n < NUM_CH; n++) begin
            if (bus_addr[7:4] == 4'(n + 1)) begin
                unique case (offs)
                    OFF_STAT_A: rd_val = view0[n];
                    OFF_STAT_B: rd_val = view1[n];
                    OFF_MASK_A: rd_val = mask0[n];
                    OFF_MASK_B: rd_val = mask1[n];
                    default:    rd_val = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vis_q     <= 1'b0;
            summary_q <= '0;
            irq_n     <= 1'b1;
            bus_rdata <= '0;
        end else begin
            if (bus_wr && !bus_rd && bus_addr == ADDR_MODE) vis_q <= bus_wdata[0];
            if (!freeze) summary_q <= gis;
            irq_n <= ~|summary_q;
            if (bus_rd) bus_rdata <= rd_val;
        end
    end

    // R5: pin follows the summary one cycle later
    p_irq_follows_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_n == !$past(|summary_q)));
    // R6: summary frozen during read
    p_summary_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(summary_q));
    // R10: a summary read leaves it unchanged
    p_summary_read_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_SUMMARY) |=> $stable(summary_q));
endmodule

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
    localparam int NC = 4;
    localparam int W  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic            bus_rd = 1'b0, bus_wr = 1'b0;
    logic [W-1:0]    bus_wdata = '0;
    logic [W-1:0]    bus_rdata;
    logic [NC*W-1:0] evt_a = '0, evt_b = '0;
    logic            irq_n;
    int              n_chk = 0, n_fail = 0;
    logic [7:0]      d;

    always #2 clk = ~clk;

    irq_aggregator u_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_a(evt_a), .evt_b(evt_b), .irq_n(irq_n)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    function automatic logic [7:0] base(input int ch);
        return 8'((ch + 1) * 16);
    endfunction

    task automatic pulse(input int ch, input int r, input int b);
        @(negedge clk);
        if (r == 0) evt_a[ch*W + b] = 1'b1; else evt_b[ch*W + b] = 1'b1;
        @(negedge clk);
        evt_a = '0; evt_b = '0;
    endtask

    task automatic set_all_masks(input logic [7:0] v);
        for (int c = 0; c < NC; c++) begin
            wr(base(c) + 8'd2, v);
            wr(base(c) + 8'd3, v);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "irq_n", int'(irq_n), 1);
        rd(8'h00, d); check("R1", "summary", d, 0);
        rd(8'h04, d); check("R1", "mode", d, 0);
        for (int c = 0; c < NC; c++) begin
            rd(base(c) + 8'd2, d); check("R1", "maskA", d, 8'hFF);
            rd(base(c) + 8'd3, d); check("R1", "maskB", d, 8'hFF);
            rd(base(c),        d); check("R1", "statA", d, 0);
        end
        rd(8'h08, d); check("R9", "unmapped", d, 0);

        // R2 default mode, all masked: sweep every event bit
        for (int c = 0; c < NC; c++)
            for (int r = 0; r < 2; r++)
                for (int b = 0; b < W; b++) begin
                    pulse(c, r, b);
                    settle();
                    check("R2", "irq_n masked", int'(irq_n), 1);
                    rd(base(c) + 8'(r), d); check("R2", "masked stat", d, 0);
                end

        // R3/R4/R5/R9 unmasked sweep
        set_all_masks(8'h00);
        rd(base(2) + 8'd3, d); check("R9", "mask readback", d, 0);
        for (int c = 0; c < NC; c++)
            for (int r = 0; r < 2; r++)
                for (int b = 0; b < W; b++) begin
                    pulse(c, r, b);
                    @(negedge clk); check("R5", "irq_n at E+2", int'(irq_n), 1);
                    @(negedge clk); check("R5", "irq_n at E+3", int'(irq_n), 0);
                    rd(8'h00, d); check("R3", "summary ptr", d, 1 << c);
                    rd(8'h00, d); check("R10", "summary kept", d, 1 << c);
                    rd(base(c) + 8'(1 - r), d); check("R9", "other reg", d, 0);
                    rd(base(c) + 8'(r), d); check("R4", "stat value", d, 1 << b);
                    settle();
                    rd(base(c) + 8'(r), d); check("R4", "cleared", d, 0);
                    settle();
                    rd(8'h00, d); check("R4", "summary released", d, 0);
                    check("R5", "irq_n released", int'(irq_n), 1);
                end

        // R4 partial release: two registers pending in channel 2
        pulse(2, 0, 1); pulse(2, 1, 6); settle();
        rd(base(2), d); check("R4", "ch2 A", d, 8'h02);
        settle();
        rd(8'h00, d); check("R4", "ch2 still pending", d, 8'h04);
        check("R5", "irq held", int'(irq_n), 0);
        rd(base(2) + 8'd1, d); check("R4", "ch2 B", d, 8'h40);
        settle();
        rd(8'h00, d); check("R4", "ch2 done", d, 0);
        check("R5", "irq off", int'(irq_n), 1);

        // R10 two channels pending
        pulse(0, 0, 0); pulse(3, 1, 7); settle();
        rd(8'h00, d); check("R10", "two channels", d, 8'h09);
        rd(base(0), d); settle();
        rd(8'h00, d); check("R10", "ch3 left", d, 8'h08);
        rd(base(3) + 8'd1, d); check("R3", "ch3 B", d, 8'h80);
        settle();

        // R6 event in the read cycle
        @(negedge clk); bus_addr = base(1); bus_rd = 1'b1; evt_a[1*W + 3] = 1'b1;
        @(negedge clk); bus_rd = 1'b0; evt_a = '0; d = bus_rdata;
        check("R6", "read during event", d, 0);
        settle();
        check("R6", "irq from held event", int'(irq_n), 0);
        rd(base(1), d); check("R6", "held event merged", d, 8'h08);
        // R6 event in the hold cycle
        @(negedge clk); bus_addr = base(1); bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; evt_a[1*W + 5] = 1'b1; d = bus_rdata;
        @(negedge clk); evt_a = '0;
        check("R6", "read before hold event", d, 0);
        settle();
        rd(base(1), d); check("R6", "hold event merged", d, 8'h20);
        settle();

        // R7 visible mode sweep, all masked
        set_all_masks(8'hFF);
        wr(8'h04, 8'h01);
        rd(8'h04, d); check("R9", "mode readback", d, 1);
        for (int c = 0; c < NC; c++)
            for (int r = 0; r < 2; r++)
                for (int b = 0; b < W; b += 3) begin
                    pulse(c, r, b); settle();
                    check("R7", "irq_n visible", int'(irq_n), 1);
                    rd(8'h00, d); check("R7", "summary visible", d, 0);
                    rd(base(c) + 8'(r), d); check("R7", "visible stat", d, 1 << b);
                end

        // R8 unmask an already captured bit
        pulse(2, 1, 4); settle();
        check("R8", "irq before unmask", int'(irq_n), 1);
        wr(base(2) + 8'd3, 8'hEF);
        settle();
        check("R8", "irq after unmask", int'(irq_n), 0);
        rd(8'h00, d); check("R8", "summary after unmask", d, 8'h04);
        rd(base(2) + 8'd1, d); check("R8", "stat", d, 8'h10);
        settle();
        check("R8", "irq after ack", int'(irq_n), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule